// File: doc/BRIEF.md
# Interrupt Line Source Selector

This block drives one interrupt line for a peripheral. The line can come from three kinds of source. The first is a vector of pending interrupt register bits. The second is a start-of-frame (SOF) event seen on the upstream bus. The third is a pair of endpoint events: a valid packet arriving in one endpoint buffer, and a command validating a second endpoint buffer.

A small configuration register holds four control bits:

- **Mode bit:** adds SOF as an extra interrupt source.
- **Override bit:** makes SOF the only source that can drive the line.
- **Two endpoint enables:** gate the two endpoint events. Software normally turns these off while a DMA transfer runs, so the CPU is not interrupted for every buffer.

SOF and the two endpoint events arrive as single-cycle pulses. Each is latched into a sticky pending flag, and software clears a flag through a clear input when it reads the matching status. The line itself is registered, so it cannot glitch.

Top module: `irq_line_sel`

## Requirements
- R1: After reset, `irq_o` is 0, all four configuration bits are 0 and all latched flags are 0. In this state neither an SOF pulse nor an endpoint pulse raises `irq_o`.
- R2: When the override bit is 0, `irq_o` is 1 in the cycle after any bit of `pend_i` is 1. It returns to 0 in the cycle after all sources are quiet.
- R3: When the mode bit and the override bit are both 0, a latched SOF flag has no effect on `irq_o`.
- R4: When the mode bit is 1 and the override bit is 0, an SOF pulse raises `irq_o` two cycles after the pulse. The line stays high until the SOF flag is cleared. `pend_i` bits still raise `irq_o` in this mode.
- R5: When the override bit is 1, `irq_o` follows only the latched SOF flag, whatever the mode bit is. `pend_i` and both endpoint flags are ignored.
- R6: An endpoint-A pulse (`ep_pkt_i`) is latched only while the endpoint-A enable is 1. While the override bit is 0, the latched flag ANDed with the enable raises `irq_o`.
- R7: An endpoint-B pulse (`ep_valid_i`) is latched only while the endpoint-B enable is 1. While the override bit is 0, the latched flag ANDed with the enable raises `irq_o`.
- R8: Clearing an endpoint enable masks that endpoint's latched flag from `irq_o` in the next cycle, but does not erase the flag. Setting the enable again lets the flag raise `irq_o` again.
- R9: `clr_i` bit 0 clears the SOF flag, bit 1 the endpoint-A flag and bit 2 the endpoint-B flag. A clear takes effect at the next edge. A new event in the same cycle as its clear wins, and the flag stays set.
- R10: A cycle with `cfg_we_i` high loads `cfg_wdata_i` into the configuration register with this bit layout: bit 0 mode, bit 1 override, bit 2 endpoint-A enable, bit 3 endpoint-B enable. The new value affects `irq_o` from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data (layout in R10) |
| pend_i | input | NUM_PEND | Pending interrupt register bits (level) |
| sof_i | input | 1 | Start-of-frame pulse |
| ep_pkt_i | input | 1 | Endpoint-A valid-packet pulse |
| ep_valid_i | input | 1 | Endpoint-B buffer-validated pulse |
| clr_i | input | 3 | Flag clear strobes (SOF, endpoint A, endpoint B) |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions take all inputs to be synchronous to `clk` and free of X after reset. They treat event and clear strobes as plain per-cycle levels, and they assume the configuration register changes only on a write cycle.

The bench drives every input on the falling edge and holds it through a full cycle. Each pulse lasts exactly one cycle. Configuration writes go out one at a time, and the bench waits out the two-register latency before it samples `irq_o`.

// File: rtl/irq_line_sel_pkg.sv
package irq_line_sel_pkg;

  localparam int EVT_SOF = 0;
  localparam int EVT_EPA = 1;
  localparam int EVT_EPB = 2;
  localparam int NUM_EVT = 3;
  localparam int CFG_W   = 4;

  // bit 0 is pin_mode, bit 3 is epb_en
  typedef struct packed {
    logic epb_en;
    logic epa_en;
    logic sof_only;
    logic pin_mode;
  } irq_cfg_t;

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_line_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output irq_cfg_t         cfg_o
);

  irq_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = irq_cfg_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R10: without a write the configuration holds
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> cfg_q == $past(cfg_q));

endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);

  logic [WIDTH-1:0] flag_q, flag_d;

  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    // set takes priority over clear
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr_i[g]) flag_d[g] = 1'b0;
      if (set_i[g]) flag_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);

    assert_setwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_out_mux.sv
module irq_out_mux
  import irq_line_sel_pkg::*;
#(
  parameter int NUM_PEND = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  irq_cfg_t            cfg_i,
  input  logic [NUM_PEND-1:0] pend_i,
  input  logic [NUM_EVT-1:0]  flag_i,
  output logic                irq_o
);

  logic normal_src, epa_src, epb_src, sof_src;
  logic irq_d, irq_q;

  always_comb begin
    sof_src    = flag_i[EVT_SOF];
    epa_src    = flag_i[EVT_EPA] & cfg_i.epa_en;
    epb_src    = flag_i[EVT_EPB] & cfg_i.epb_en;
    normal_src = (|pend_i) | epa_src | epb_src;
    if (cfg_i.sof_only) irq_d = sof_src;
    else                irq_d = normal_src | (cfg_i.pin_mode & sof_src);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_override_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.sof_only && !flag_i[EVT_SOF]) |=> !irq_o);

  assert_pend_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.sof_only && (|pend_i)) |=> irq_o);

  assert_sof_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.sof_only && !cfg_i.pin_mode && pend_i == '0 &&
     !(flag_i[EVT_EPA] && cfg_i.epa_en) && !(flag_i[EVT_EPB] && cfg_i.epb_en))
    |=> !irq_o);

  assert_pin_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.pin_mode && flag_i[EVT_SOF]) |=> irq_o);

endmodule

// File: rtl/irq_line_sel.sv
module irq_line_sel
  import irq_line_sel_pkg::*;
#(
  parameter int NUM_PEND = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic [NUM_PEND-1:0] pend_i,
  input  logic                sof_i,
  input  logic                ep_pkt_i,
  input  logic                ep_valid_i,
  input  logic [NUM_EVT-1:0]  clr_i,
  output logic                irq_o
);

  irq_cfg_t           cfg;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_flag;

  irq_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EVT_SOF] = sof_i;
    evt_set[EVT_EPA] = ep_pkt_i   & cfg.epa_en;
    evt_set[EVT_EPB] = ep_valid_i & cfg.epb_en;
  end

  irq_evt_latch #(.WIDTH(NUM_EVT)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_set),
    .clr_i  (clr_i),
    .flag_o (evt_flag)
  );

  irq_out_mux #(.NUM_PEND(NUM_PEND)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg),
    .pend_i (pend_i),
    .flag_i (evt_flag),
    .irq_o  (irq_o)
  );

  // R6: a disabled endpoint-A pulse leaves an empty flag empty
  assert_epa_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.epa_en && !evt_flag[EVT_EPA]) |=> !evt_flag[EVT_EPA]);

  // R7: a disabled endpoint-B pulse leaves an empty flag empty
  assert_epb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.epb_en && !evt_flag[EVT_EPB]) |=> !evt_flag[EVT_EPB]);

endmodule

// File: tb/irq_line_sel_test.sv
module irq_line_sel_test;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_wdata = '0;
  logic [NP-1:0] pend = '0;
  logic          sof = 1'b0, ep_pkt = 1'b0, ep_valid = 1'b0;
  logic [2:0]    clr = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_line_sel #(.NUM_PEND(NP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .pend_i(pend), .sof_i(sof), .ep_pkt_i(ep_pkt), .ep_valid_i(ep_valid),
    .clr_i(clr), .irq_o(irq)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq, exp, $time);
    end
  endtask

  // bit0 mode, bit1 override, bit2 epA en, bit3 epB en (R10)
  task automatic write_cfg(logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step();
    cfg_we = 1'b0; step();
  endtask

  task automatic pulse_sof();   sof = 1'b1;      step(); sof = 1'b0;      step(); endtask
  task automatic pulse_epa();   ep_pkt = 1'b1;   step(); ep_pkt = 1'b0;   step(); endtask
  task automatic pulse_epb();   ep_valid = 1'b1; step(); ep_valid = 1'b0; step(); endtask
  task automatic clear(logic [2:0] m); clr = m;  step(); clr = '0;        step(); endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
    pulse_sof();
    check("R1/R3 sof with reset cfg", 1'b0);
    pulse_epa();
    check("R1/R6 epA with enable off", 1'b0);
    pulse_epb();
    check("R1/R7 epB with enable off", 1'b0);
    write_cfg(4'b1100);
    check("R6/R7 no flag latched while disabled", 1'b0);
    write_cfg(4'b0000);
    clear(3'b111);
  endtask

  task automatic t_normal();
    pend = 8'h01; step(); check("R2 pend bit0", 1'b1);
    pend = 8'h00; step(); check("R2 quiet", 1'b0);
    pend = 8'h80; step(); check("R2 pend bit7", 1'b1);
    pend = 8'h24; step(); check("R2 two bits", 1'b1);
    pend = 8'h00; step(); check("R2 quiet again", 1'b0);
  endtask

  task automatic t_pin_mode();
    pulse_sof();
    check("R3 latched sof ignored with mode 0", 1'b0);
    write_cfg(4'b0001);                // R10 mode bit
    check("R4 pending sof visible after mode set", 1'b1);
    clear(3'b001);
    check("R9 sof clear", 1'b0);
    pulse_sof();
    check("R4 sof raises line", 1'b1);
    step(5);
    check("R4 line held until clear", 1'b1);
    clear(3'b001);
    check("R9 sof cleared again", 1'b0);
    pend = 8'h10; step(); check("R4 pend still active", 1'b1);
    pend = 8'h00; step();
    sof = 1'b1; clr = 3'b001; step(); sof = 1'b0; clr = '0; step();
    check("R9 set wins over clear", 1'b1);
    clear(3'b001);
    write_cfg(4'b0000);
  endtask

  task automatic t_sof_only();
    write_cfg(4'b0010);
    pend = 8'hFF; step(2);
    check("R5 pend ignored in override", 1'b0);
    pend = 8'h00;
    pulse_sof();
    check("R5 sof drives override", 1'b1);
    clear(3'b001);
    check("R5 quiet after clear", 1'b0);
    write_cfg(4'b1111);
    pend = 8'h03; step(); pulse_epa(); pulse_epb();
    check("R5 override beats mode and endpoints", 1'b0);
    pend = 8'h00;
    write_cfg(4'b1100);
    check("R6/R7 endpoint flags visible once override off", 1'b1);
    clear(3'b110);
    check("R9 endpoint flags cleared", 1'b0);
    write_cfg(4'b0000);
  endtask

  task automatic t_endpoints();
    write_cfg(4'b0100);
    pulse_epa();
    check("R6 epA raises line", 1'b1);
    clear(3'b010);
    check("R9 epA clear", 1'b0);
    write_cfg(4'b1000);
    pulse_epb();
    check("R7 epB raises line", 1'b1);
    write_cfg(4'b0000);
    check("R8 disable masks epB flag", 1'b0);
    write_cfg(4'b1000);
    check("R8 flag kept and unmasked", 1'b1);
    clear(3'b100);
    check("R9 epB clear", 1'b0);
    write_cfg(4'b0000);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_normal();
    t_pin_mode();
    t_sof_only();
    t_endpoints();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule